// File: doc/BRIEF.md
# System Clock Divider with Fuse-Selected Start-Up Rate

This block derives the system clock rate from a fast master clock. Rather than producing a second clock net, it raises a one-cycle enable pulse, `tick_o`, once every 2^n master cycles. The CPU and every synchronous peripheral qualify their flops with this pulse, so they all slow down by the same factor. A four-bit select register picks n. Software may rewrite the register at any time, and its current value can always be read back.

A start-up fuse input chooses the value the select register takes during reset. With the fuse clear, the device starts undivided (select 0). With the fuse set, it starts at divide-by-8 (select 3), which keeps a fast source within the device's limits until software raises the rate. The fuse affects only the reset value: any later write is accepted whatever the fuse says. A change of rate never cuts a divided period short. The pulse spacing switches to the new factor only at the end of the period in progress.

Top module: `sysclk_prescaler`

## Requirements
- R1: With `slow_start_i` low during reset, `sel_o` reads 0 after reset. `tick_o` is then high on every master cycle, starting with the first cycle after reset.
- R2: With `slow_start_i` high during reset, `sel_o` reads 3 after reset. The first `tick_o` pulse comes in the 8th cycle after reset (7 clock edges after release), and pulses then repeat every 8 cycles.
- R3: A write (`wr_en_i` high at a clock edge) loads `wr_data_i` into the select register, whatever the value of `slow_start_i`. `sel_o` shows the new value from the next cycle.
- R4: A select value n from 0 to 8 spaces successive `tick_o` pulses exactly 2^n master cycles apart. Each pulse is high for a single cycle when n > 0.
- R5: Select values 9 to 15 are reserved and give the same spacing as 8, which is 256 cycles.
- R6: A new select value takes effect only at a period boundary. The period in progress when a write lands keeps its old length. A write in a cycle where `tick_o` is high sets the length of the period that starts at that edge.
- R7: When several writes land within one period, only the value held by the select register at the boundary sets the next period.
- R8: While `wr_en_i` is low, `wr_data_i` has no effect on `sel_o` or on the pulse spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| arst_ni | input | 1 | Asynchronous reset, active low |
| slow_start_i | input | 1 | Start-up fuse: 1 resets the select register to divide-by-8, 0 to divide-by-1 |
| wr_en_i | input | 1 | Write strobe for the select register |
| wr_data_i | input | 4 | New select value |
| sel_o | output | 4 | Readback of the select register |
| tick_o | output | 1 | Divided-rate clock enable, one master cycle wide |

## Verification
The assertions assume that `slow_start_i` is static while the block runs. It is a fuse, so it is only expected to change while reset is held. The bench therefore changes it only inside its reset task, before releasing `arst_ni`. The assertions also assume that `wr_en_i` and `wr_data_i` are stable around the rising edge. The bench drives all inputs on falling edges and samples outputs there as well. Reserved select values are part of the legal input range, and both ends of that range are applied.

// File: rtl/sysclk_psc_pkg.sv
package sysclk_psc_pkg;
  localparam int unsigned PSC_SEL_W     = 4;
  localparam int unsigned PSC_MAX_SHIFT = 8;
  localparam int unsigned PSC_FUSE_SEL  = 3;

  // Clamp a select code to the largest supported shift.
  function automatic int unsigned psc_clamp(input int unsigned code, input int unsigned max_shift);
    return (code > max_shift) ? max_shift : code;
  endfunction
endpackage

// File: rtl/psc_sel_reg.sv
module psc_sel_reg #(
  parameter int unsigned SEL_W    = 4,
  parameter int unsigned FUSE_SEL = 3
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             fuse_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_data_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [SEL_W-1:0] sel_next_o
);
  localparam logic [SEL_W-1:0] FUSE_CODE = SEL_W'(FUSE_SEL);
  localparam logic [SEL_W-1:0] FAST_CODE = '0;

  logic [SEL_W-1:0] sel_q;

  // The fuse is static, so it acts as a reset-value select.
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni)     sel_q <= fuse_i ? FUSE_CODE : FAST_CODE;
    else if (wr_en_i) sel_q <= wr_data_i;
  end

  // A write in a boundary cycle is forwarded so that it sets the next period.
  assign sel_next_o = wr_en_i ? wr_data_i : sel_q;
  assign sel_o      = sel_q;

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!arst_ni)
    wr_en_i |=> sel_q == $past(wr_data_i)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !wr_en_i |=> $stable(sel_q)); // R8
endmodule

// File: rtl/psc_decode.sv
module psc_decode #(
  parameter int unsigned SEL_W     = 4,
  parameter int unsigned MAX_SHIFT = 8,
  parameter int unsigned SHW       = $clog2(MAX_SHIFT + 1)
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [SHW-1:0]   shift_o
);
  localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(MAX_SHIFT);

  always_comb begin
    if (sel_i > TOP_CODE) shift_o = SHW'(MAX_SHIFT);
    else                  shift_o = SHW'(sel_i);
  end
endmodule

// File: rtl/psc_divider.sv
module psc_divider #(
  parameter int unsigned MAX_SHIFT  = 8,
  parameter int unsigned SHW        = $clog2(MAX_SHIFT + 1),
  parameter int unsigned FUSE_SHIFT = 3,
  parameter int unsigned CNT_W      = (MAX_SHIFT > 0) ? MAX_SHIFT : 1
) (
  input  logic           clk_i,
  input  logic           arst_ni,
  input  logic           fuse_i,
  input  logic [SHW-1:0] shift_next_i,
  output logic           tick_o
);
  localparam logic [SHW-1:0]   SLOW_SHIFT = SHW'(FUSE_SHIFT);
  localparam logic [CNT_W-1:0] ALL_ONES   = '1;

  logic [SHW-1:0]   shift_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             tick;

  assign limit = ~(ALL_ONES << shift_q);
  assign tick  = (cnt_q == limit);

  // The shift is latched only on the terminal count, so periods never end early.
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q   <= '0;
      shift_q <= fuse_i ? SLOW_SHIFT : '0;
    end else if (tick) begin
      cnt_q   <= '0;
      shift_q <= shift_next_i;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign tick_o = tick;

  AST_SHIFT_HOLD: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !tick |=> $stable(shift_q)); // R6
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    tick |=> (shift_q == '0) || !tick_o); // R4
  AST_SHIFT_RANGE: assert property (@(posedge clk_i) disable iff (!arst_ni)
    shift_q <= SHW'(MAX_SHIFT)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!arst_ni)
    cnt_q <= limit); // R4
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import sysclk_psc_pkg::*;
#(
  parameter int unsigned SEL_W     = PSC_SEL_W,
  parameter int unsigned MAX_SHIFT = PSC_MAX_SHIFT,
  parameter int unsigned FUSE_SEL  = PSC_FUSE_SEL
) (
  input  logic             clk_i,
  input  logic             arst_ni,
  input  logic             slow_start_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_data_i,
  output logic [SEL_W-1:0] sel_o,
  output logic             tick_o
);
  localparam int unsigned SHW        = $clog2(MAX_SHIFT + 1);
  localparam int unsigned FUSE_SHIFT = psc_clamp(FUSE_SEL, MAX_SHIFT);

  logic [SEL_W-1:0] sel_next;
  logic [SHW-1:0]   shift_next;

  psc_sel_reg #(.SEL_W(SEL_W), .FUSE_SEL(FUSE_SEL)) u_sel (
    .clk_i      (clk_i),
    .arst_ni    (arst_ni),
    .fuse_i     (slow_start_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .sel_o      (sel_o),
    .sel_next_o (sel_next)
  );

  psc_decode #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT), .SHW(SHW)) u_dec (
    .sel_i   (sel_next),
    .shift_o (shift_next)
  );

  psc_divider #(.MAX_SHIFT(MAX_SHIFT), .SHW(SHW), .FUSE_SHIFT(FUSE_SHIFT)) u_div (
    .clk_i        (clk_i),
    .arst_ni      (arst_ni),
    .fuse_i       (slow_start_i),
    .shift_next_i (shift_next),
    .tick_o       (tick_o)
  );
endmodule

// File: tb/test_sysclk_prescaler.sv
module test_sysclk_prescaler;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       fuse = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'd0;
  logic [3:0] sel;
  logic       tick;
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  sysclk_prescaler i_sysclk_prescaler (
    .clk_i(clk), .arst_ni(arst_n), .slow_start_i(fuse),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .sel_o(sel), .tick_o(tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit f);
    @(negedge clk);
    arst_n = 1'b0; fuse = f; wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    arst_n = 1'b1;
  endtask

  task automatic write_sel(input logic [3:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_tick();
    int g = 0;
    do begin @(negedge clk); g++; end while (!tick && g < 1000);
  endtask

  task automatic measure(output int p);
    int n = 0;
    wait_tick();
    do begin @(negedge clk); n++; end while (!tick && n < 1000);
    p = n;
  endtask

  task automatic set_and_measure(input logic [3:0] v, output int p);
    @(negedge clk);
    write_sel(v);
    wait_tick();
    measure(p);
  endtask

  task automatic t_fuse_clear();
    int n = 0;
    do_reset(1'b0);
    check(sel == 4'd0, "R1 sel after reset", sel, 0);
    do begin @(negedge clk); n++; end while (!tick && n < 1000);
    check(n == 1, "R1 first tick", n, 1);
    @(negedge clk);
    check(tick == 1'b1, "R1 tick every cycle", tick, 1);
  endtask

  task automatic t_fuse_set();
    int n = 0;
    int p;
    do_reset(1'b1);
    check(sel == 4'd3, "R2 sel after reset", sel, 3);
    do begin @(negedge clk); n++; end while (!tick && n < 1000);
    check(n == 7, "R2 first tick", n, 7);
    measure(p);
    check(p == 8, "R2 start-up period", p, 8);
  endtask

  task automatic t_write_any();
    int p;
    do_reset(1'b1);
    @(negedge clk);
    write_sel(4'd0);
    check(sel == 4'd0, "R3 write 0 under fuse set", sel, 0);
    do_reset(1'b0);
    @(negedge clk);
    write_sel(4'd15);
    check(sel == 4'd15, "R3 write 15 under fuse clear", sel, 15);
    wait_tick();
    measure(p);
    check(p == 256, "R5 select 15 period", p, 256);
  endtask

  task automatic t_sweep();
    int p;
    do_reset(1'b0);
    for (int s = 0; s <= 9; s++) begin
      set_and_measure(4'(s), p);
      if (s <= 8) check(p == (1 << s), "R4 period for select", p, 1 << s);
      else        check(p == 256, "R5 select 9 period", p, 256);
    end
  endtask

  task automatic t_boundary();
    int n = 0;
    int p;
    do_reset(1'b1);
    wait_tick();
    @(negedge clk);
    @(negedge clk);
    write_sel(4'd1);            // mid-period write, 3 cycles past the tick
    n = 3;
    while (!tick && n < 1000) begin @(negedge clk); n++; end
    check(n == 8, "R6 current period keeps old length", n, 8);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick && n < 1000);
    check(n == 2, "R6 next period uses new length", n, 2);
    // Write in a tick cycle: applies to the period starting at that edge.
    write_sel(4'd2);
    n = 1;
    while (!tick && n < 1000) begin @(negedge clk); n++; end
    check(n == 4, "R6 write on boundary applies at once", n, 4);
  endtask

  task automatic t_last_write();
    int n;
    int p;
    do_reset(1'b1);
    wait_tick();
    @(negedge clk);
    write_sel(4'd5);
    write_sel(4'd2);
    n = 3;
    while (!tick && n < 1000) begin @(negedge clk); n++; end
    check(n == 8, "R7 period in progress unchanged", n, 8);
    measure(p);
    check(p == 4, "R7 last write wins", p, 4);
  endtask

  task automatic t_ignored();
    int p;
    do_reset(1'b1);
    wr_en = 1'b0;
    for (int k = 0; k < 12; k++) begin
      wr_data = 4'(k);
      @(negedge clk);
    end
    check(sel == 4'd3, "R8 data ignored without strobe", sel, 3);
    measure(p);
    check(p == 8, "R8 period unchanged", p, 8);
  endtask

  initial begin
    t_fuse_clear();
    t_fuse_set();
    t_write_any();
    t_sweep();
    t_boundary();
    t_last_write();
    t_ignored();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule